// File: doc/BRIEF.md
# Stereo Digital Volume Control with Peak Meter

This block sits in a two-channel audio playback path. It accepts signed 24-bit left and right samples together on a single strobe. It attenuates each channel by its own 8-bit volume code on a logarithmic scale of 0.375 dB per code. Two cycles after each accepted sample it presents the scaled pair with a one-cycle valid pulse. Each channel also has a mute bit, and both channels start muted so that nothing is heard while software configures the path.

Alongside the audio path, the block meters each channel. It keeps a peak-magnitude register that clears when software reads it. It also raises a per-channel flag once the incoming data has been zero for a long run. A small register port with a one-cycle read latency sets the volume codes and mute bits and reads back the registers.

The left and right channels share one multiplier, and a three-state sequencer controls it. The states are `ST_IDLE`, `ST_LEFT` and `ST_RIGHT`:

- `ST_IDLE` waits for a strobe and moves to `ST_LEFT` when it accepts a sample. With no strobe it stays in `ST_IDLE`.
- `ST_LEFT` writes the scaled left sample and always moves to `ST_RIGHT`.
- `ST_RIGHT` writes the scaled right sample, pulses the valid output and always returns to `ST_IDLE`.

Top module: `stereo_vol_meter`

## Requirements
- R1: Each channel has an 8-bit volume code. Code k selects the gain G[k] = round(32768 * 10^(-0.375*k/20)), so code 0 is unity gain (32768) and each step down adds 0.375 dB of attenuation.
- R2: An unmuted output equals (x*G[k] + 16384) >>> 15, saturated to the signed 24-bit range. Each channel uses its own code and mute bit.
- R3: After reset, both mute bits are 1 and both volume codes are 0. The outputs, `out_valid`, the peak registers and the zero flags are all 0. A sample sent before any register write produces zero outputs.
- R4: Bit 0 of the mute register mutes the left channel and bit 1 mutes the right. A muted channel outputs 0 whatever its volume code, while the other channel is unaffected.
- R5: A sample is accepted on a clock edge where `in_valid` is high and the sequencer is idle. The scaled pair appears with `out_valid` high for exactly one cycle, starting on the second edge after the accepting edge. The outputs then hold their value. Strobes must be at least three cycles apart; a strobe that arrives while the sequencer is busy is dropped.
- R6: Each peak register holds the largest magnitude of that channel's accepted input samples since it was last read. The sample -8388608 counts as magnitude 8388607.
- R7: Reading a peak register returns its held value on `rd_data` and clears it to 0. If a sample is accepted on the same edge, the register instead loads that sample's magnitude.
- R8: A channel's zero flag rises after 1024 consecutive accepted samples that are zero on that channel. It falls on the first accepted non-zero sample, and each channel is independent of the other.
- R9: The register addresses are: 0 for the left volume, 1 for the right volume, 2 for the mute bits, 3 for the left peak and 4 for the right peak. `rd_data` is valid the cycle after `rd_en`, with values zero-extended. Writes to addresses 3 and 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe for the left/right pair |
| in_l | input | 24 | Left input sample, signed |
| in_r | input | 24 | Right input sample, signed |
| out_valid | output | 1 | One-cycle pulse marking a new output pair |
| out_l | output | 24 | Attenuated left sample, signed |
| out_r | output | 24 | Attenuated right sample, signed |
| zero_l | output | 1 | Left zero-run flag |
| zero_r | output | 1 | Right zero-run flag |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read enable |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 24 | Registered read data |

## Verification
Some properties are checked on every cycle:

- The valid pulse lasts one cycle and always follows the right-channel state.
- A peak register never falls unless it is being read.
- A read with no concurrent sample leaves the peak register at zero.
- A zero flag rises only after an accepted zero sample and drops after an accepted non-zero one.

The bench scenarios are needed for the rest:

- the exact attenuated values for each volume code, including the rounding;
- the per-channel mute;
- the reset defaults;
- the exact 1024-sample threshold;
- the case where a read and a sample arrive together.

// File: rtl/volpk_pkg.sv
package volpk_pkg;

    localparam real STEP_DB = 0.375;
    localparam int  REG_AW  = 3;

    localparam logic [REG_AW-1:0] A_VOL_L  = 3'd0;
    localparam logic [REG_AW-1:0] A_VOL_R  = 3'd1;
    localparam logic [REG_AW-1:0] A_MUTE   = 3'd2;
    localparam logic [REG_AW-1:0] A_PEAK_L = 3'd3;
    localparam logic [REG_AW-1:0] A_PEAK_R = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } seq_state_e;

    // Fixed-point gain for one volume code: 2^frac scaled, rounded to nearest.
    function automatic int gain_fix(int k, int frac);
        real g;
        g = (2.0 ** frac) * (10.0 ** (-(STEP_DB * k) / 20.0));
        return $rtoi(g + 0.5);
    endfunction

endpackage

// File: rtl/volpk_gain_rom.sv
module volpk_gain_rom
    import volpk_pkg::*;
#(
    parameter int VW = 8,
    parameter int GW = 16
) (
    input  logic [VW-1:0] code,
    output logic [GW-1:0] gain
);
    localparam int STEPS = 1 << VW;

    logic [GW-1:0] tab [STEPS];

    for (genvar k = 0; k < STEPS; k++) begin : g_tab
        assign tab[k] = GW'(gain_fix(k, GW - 1));
    end

    assign gain = tab[code];

endmodule

// File: rtl/volpk_scaler.sv
module volpk_scaler #(
    parameter int DW = 24,
    parameter int GW = 16
) (
    input  logic signed [DW-1:0] x,
    input  logic        [GW-1:0] gain,
    input  logic                 mute,
    output logic signed [DW-1:0] y
);
    localparam int PW = DW + GW + 1;
    localparam int SH = GW - 1;
    localparam logic signed [PW-1:0] HALF = {{(PW-SH){1'b0}}, 1'b1, {(SH-1){1'b0}}};
    localparam logic signed [PW-1:0] HI   = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW-1:0] LO   = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shr;
    logic signed [PW-1:0] sat;

    always_comb begin
        prod = $signed(PW'(x)) * $signed(PW'({1'b0, gain}));
        shr  = (prod + HALF) >>> SH;
        if (shr > HI) begin
            sat = HI;
        end else if (shr < LO) begin
            sat = LO;
        end else begin
            sat = shr;
        end
        y = mute ? '0 : sat[DW-1:0];
    end

endmodule

// File: rtl/volpk_chan_meter.sv
module volpk_chan_meter #(
    parameter int DW   = 24,
    parameter int ZRUN = 1024
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    input  logic signed [DW-1:0] x,
    input  logic                 rd_clr,
    output logic        [DW-1:0] peak,
    output logic                 zero
);
    localparam int CW = $clog2(ZRUN + 1);
    localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] MOST_POS = {1'b0, {(DW-1){1'b1}}};

    logic [DW-1:0] mag;
    logic [CW-1:0] run_q;

    always_comb begin
        if (x == MOST_NEG) begin
            mag = MOST_POS;
        end else if (x[DW-1]) begin
            mag = DW'(-x);
        end else begin
            mag = x;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            peak <= '0;
        end else if (rd_clr) begin
            peak <= take ? mag : '0;
        end else if (take && (mag > peak)) begin
            peak <= mag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (take) begin
            if (x != '0) begin
                run_q <= '0;
            end else if (run_q != CW'(ZRUN)) begin
                run_q <= run_q + CW'(1);
            end
        end
    end

    assign zero = (run_q == CW'(ZRUN));

endmodule

// File: rtl/stereo_vol_meter.sv
module stereo_vol_meter
    import volpk_pkg::*;
#(
    parameter int DW   = 24,
    parameter int GW   = 16,
    parameter int VW   = 8,
    parameter int ZRUN = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DW-1:0]     in_l,
    input  logic signed [DW-1:0]     in_r,
    output logic                     out_valid,
    output logic signed [DW-1:0]     out_l,
    output logic signed [DW-1:0]     out_r,
    output logic                     zero_l,
    output logic                     zero_r,
    input  logic                     wr_en,
    input  logic [REG_AW-1:0]        wr_addr,
    input  logic [VW-1:0]            wr_data,
    input  logic                     rd_en,
    input  logic [REG_AW-1:0]        rd_addr,
    output logic [DW-1:0]            rd_data
);
    localparam int NCH = 2;

    seq_state_e state_q, state_d;

    logic [VW-1:0]        vol_l_q, vol_r_q;
    logic [NCH-1:0]       mute_q;
    logic signed [DW-1:0] smp_l_q, smp_r_q;
    logic                 take;

    logic                 on_right;
    logic signed [DW-1:0] mul_x;
    logic [VW-1:0]        mul_code;
    logic                 mul_mute;
    logic [GW-1:0]        mul_gain;
    logic signed [DW-1:0] scaled;

    logic signed [DW-1:0] ch_x    [NCH];
    logic [DW-1:0]        ch_peak [NCH];
    logic [NCH-1:0]       ch_clr;
    logic [NCH-1:0]       ch_zero;

    assign take = in_valid && (state_q == ST_IDLE);

    // Sequencer state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid) state_d = ST_LEFT;
            ST_LEFT:  state_d = ST_RIGHT;
            ST_RIGHT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Sample capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_l_q <= '0;
            smp_r_q <= '0;
        end else if (take) begin
            smp_l_q <= in_l;
            smp_r_q <= in_r;
        end
    end

    // Shared multiplier operand select
    always_comb begin
        on_right = (state_q == ST_RIGHT);
        mul_x    = on_right ? smp_r_q : smp_l_q;
        mul_code = on_right ? vol_r_q : vol_l_q;
        mul_mute = on_right ? mute_q[1] : mute_q[0];
    end

    volpk_gain_rom #(.VW(VW), .GW(GW)) u_rom (
        .code (mul_code),
        .gain (mul_gain)
    );

    volpk_scaler #(.DW(DW), .GW(GW)) u_scaler (
        .x    (mul_x),
        .gain (mul_gain),
        .mute (mul_mute),
        .y    (scaled)
    );

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_l     <= '0;
            out_r     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE:  ;
                ST_LEFT:  out_l <= scaled;
                ST_RIGHT: begin
                    out_r     <= scaled;
                    out_valid <= 1'b1;
                end
                default:  ;
            endcase
        end
    end

    // Per-channel meters
    assign ch_x[0]   = in_l;
    assign ch_x[1]   = in_r;
    assign ch_clr[0] = rd_en && (rd_addr == A_PEAK_L);
    assign ch_clr[1] = rd_en && (rd_addr == A_PEAK_R);

    for (genvar c = 0; c < NCH; c++) begin : g_meter
        volpk_chan_meter #(.DW(DW), .ZRUN(ZRUN)) u_meter (
            .clk    (clk),
            .rst_n  (rst_n),
            .take   (take),
            .x      (ch_x[c]),
            .rd_clr (ch_clr[c]),
            .peak   (ch_peak[c]),
            .zero   (ch_zero[c])
        );
    end

    assign zero_l = ch_zero[0];
    assign zero_r = ch_zero[1];

    // Register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vol_l_q <= '0;
            vol_r_q <= '0;
            mute_q  <= '1;
        end else if (wr_en) begin
            case (wr_addr)
                A_VOL_L: vol_l_q <= wr_data;
                A_VOL_R: vol_r_q <= wr_data;
                A_MUTE:  mute_q  <= wr_data[NCH-1:0];
                default: ;
            endcase
        end
    end

    // Register reads
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (rd_addr)
                A_VOL_L:  rd_data <= DW'(vol_l_q);
                A_VOL_R:  rd_data <= DW'(vol_r_q);
                A_MUTE:   rd_data <= DW'(mute_q);
                A_PEAK_L: rd_data <= ch_peak[0];
                A_PEAK_R: rd_data <= ch_peak[1];
                default:  rd_data <= '0;
            endcase
        end
    end

endmodule

// File: rtl/volpk_checker.sv
module volpk_checker
    import volpk_pkg::*;
#(
    parameter int DW = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 take,
    input logic signed [DW-1:0] in_l,
    input logic                 rd_en,
    input logic [REG_AW-1:0]    rd_addr,
    input logic                 out_valid,
    input logic                 zero_l,
    input logic [DW-1:0]        peak_l,
    input seq_state_e           state
);

    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R5
    valid_after_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(state == ST_RIGHT));

    // R8
    zero_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (in_l != '0)) |=> !zero_l);

    // R8
    zero_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_l) |-> $past(take && (in_l == '0)));

    // R6
    peak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && (rd_addr == A_PEAK_L)) |=> (peak_l >= $past(peak_l)));

    // R7
    peak_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr == A_PEAK_L) && !take) |=> (peak_l == '0));

endmodule

bind stereo_vol_meter volpk_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .in_l      (in_l),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .out_valid (out_valid),
    .zero_l    (zero_l),
    .peak_l    (ch_peak[0]),
    .state     (state_q)
);

// File: tb/test_stereo_vol_meter.sv
`timescale 1ns/1ps
module test_stereo_vol_meter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_l = '0, in_r = '0;
    logic        out_valid;
    logic [23:0] out_l, out_r;
    logic        zero_l, zero_r;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [23:0] rd_data;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    stereo_vol_meter i_stereo_vol_meter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
        .out_valid(out_valid), .out_l(out_l), .out_r(out_r),
        .zero_l(zero_l), .zero_r(zero_r),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // {vol_l, vol_r, mute, left, right}
    localparam logic [65:0] VEC [8] = '{
        {8'd0,   8'd0,   2'b00, 24'h0003E8, 24'hFFFC18},
        {8'd16,  8'd32,  2'b00, 24'h7FFFFF, 24'h800000},
        {8'd1,   8'd2,   2'b00, 24'h01E240, 24'hF6040F},
        {8'd255, 8'd128, 2'b00, 24'h7FFFFF, 24'h400000},
        {8'd8,   8'd8,   2'b01, 24'h001388, 24'h001388},
        {8'd0,   8'd0,   2'b10, 24'hFFFFF9, 24'h000007},
        {8'd100, 8'd200, 2'b00, 24'hFFFFFD, 24'h000001},
        {8'd0,   8'd255, 2'b00, 24'h800000, 24'h800000}
    };

    function automatic longint model(longint x, int k, bit m);
        longint g, p;
        if (m) return 0;
        g = longint'($rtoi(32768.0 * (10.0 ** (-0.375 * k / 20.0)) + 0.5));
        p = (x * g + 16384) >>> 15;
        if (p > 8388607) p = 8388607;
        if (p < -8388608) p = -8388608;
        return p;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output longint v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = longint'(rd_data);
    endtask

    // Returns at the negedge after the out_valid edge.
    task automatic send(logic [23:0] l, logic [23:0] r);
        @(negedge clk);
        in_valid = 1'b1; in_l = l; in_r = r;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        longint v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset state
        chk("R3 out_valid", longint'(out_valid), 0);
        chk("R3 out_l", longint'($signed(out_l)), 0);
        chk("R3 zero_l", longint'(zero_l), 0);
        chk("R3 zero_r", longint'(zero_r), 0);
        rd(3'd2, v); chk("R3 mute reset", v, 3);
        rd(3'd0, v); chk("R3 vol_l reset", v, 0);
        rd(3'd4, v); chk("R3 peak_r reset", v, 0);

        // R3 muted by default
        send(24'd1000, 24'hFFFC18);
        chk("R5 out_valid pulse", longint'(out_valid), 1);
        chk("R3 muted left", longint'($signed(out_l)), 0);
        chk("R3 muted right", longint'($signed(out_r)), 0);
        @(negedge clk);
        chk("R5 pulse one cycle", longint'(out_valid), 0);
        rd(3'd3, v); // clear peak L

        // R1 R2 R4 vector walk
        for (int i = 0; i < 8; i++) begin
            logic [65:0] e;
            e = VEC[i];
            wr(3'd0, e[65:58]);
            wr(3'd1, e[57:50]);
            wr(3'd2, {6'd0, e[49:48]});
            send(e[47:24], e[23:0]);
            chk("R5 valid in walk", longint'(out_valid), 1);
            chk("R2 left", longint'($signed(out_l)),
                model(longint'($signed(e[47:24])), int'(e[65:58]), e[48]));
            chk("R4 right", longint'($signed(out_r)),
                model(longint'($signed(e[23:0])), int'(e[57:50]), e[49]));
        end

        // R5 outputs hold after pulse
        repeat (3) @(negedge clk);
        chk("R5 hold", longint'($signed(out_l)), model(-8388608, 0, 1'b0));

        // R9 readback and ignored write to peak
        rd(3'd1, v); chk("R9 vol_r readback", v, 255);
        wr(3'd3, 8'h00);
        // R6 peak with most-negative sample
        rd(3'd3, v); chk("R6 peak_l max", v, 8388607);
        rd(3'd4, v); chk("R6 peak_r max", v, 8388607);
        rd(3'd3, v); chk("R7 peak_l cleared", v, 0);

        // R7 read in same cycle as new sample
        send(24'd500, 24'd0);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 3'd3; in_valid = 1'b1; in_l = 24'd200; in_r = 24'd0;
        @(negedge clk);
        rd_en = 1'b0; in_valid = 1'b0;
        chk("R7 concurrent read old", longint'(rd_data), 500);
        @(negedge clk);
        @(negedge clk);
        rd(3'd3, v); chk("R7 reload from sample", v, 200);

        // R8 zero run
        for (int i = 0; i < 1023; i++) send(24'd0, 24'd1);
        chk("R8 zero_l before threshold", longint'(zero_l), 0);
        send(24'd0, 24'd1);
        chk("R8 zero_l at threshold", longint'(zero_l), 1);
        chk("R8 zero_r independent", longint'(zero_r), 0);
        send(24'd0, 24'd1);
        chk("R8 zero_l stays", longint'(zero_l), 1);
        send(24'd1, 24'd1);
        chk("R8 zero_l clears", longint'(zero_l), 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule